// File: doc/BRIEF.md
# Vectored Nested-Priority Interrupt Controller

This block collects up to 32 interrupt inputs and presents them to a processor as two active-low request lines. Source 0 is the fast interrupt and drives its own line. Sources 1 and up compete for the normal request line by a 3-bit priority, where 7 is the most urgent. Each source also has a programmable trigger: level or edge, with either polarity. Each source has its own handler address. Software reads a vector register to get the handler of the winning source.

That vector read also records the winner's level on a hardware stack. While the level is on the stack, only strictly more urgent sources can raise the request line. An end-of-interrupt write removes the level again, which gives nested servicing without software bookkeeping. When the request has vanished by the time the vector is read, a programmable spurious address comes back instead. Enable bits are changed through separate set and clear registers, so no read-modify-write is needed.

A protect mode defers all side effects of the vector read until software writes the vector register, so a debugger can look at it without disturbing state. Software can also force or clear any source's latched request for testing.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset both request lines are high, all enable bits are 0, the stack is empty and the status register reads 0.
- R2: A write to the enable-set register (0x45) sets the enable bits written as 1. A write to the enable-clear register (0x46) clears the bits written as 1. No other bit changes. The enable register reads at 0x44.
- R3: The vector register (0x40) returns the handler address (0x20+n) of the eligible enabled pending source in 1..31 with the highest priority. Among equal priorities the lowest source number wins. Per-source config at 0x00+n holds priority in bits [2:0], edge mode in bit 3 and inverted polarity in bit 4.
- R4: A vector read pushes the winner's level onto the stack. While the stack is non-empty, irq_n goes low only for an enabled pending source whose priority is strictly above the top level. A write to 0x49 pops one level.
- R5: A level source is pending while its input is high, or while it is low when bit 4 is set. It follows the input without latching.
- R6: An edge source latches a pending flag on a rising edge (a falling edge when bit 4 is set). The flag stays until the source wins a vector read or a 1 is written to its bit in the pending-clear register (0x47).
- R7: If no source is eligible when the vector register is read, the read returns the spurious address (0x4A) and sets the status to 0. It still pushes an entry that an end-of-interrupt write must remove.
- R8: The status register (0x42) holds the source number chosen at the last committed vector read. The pending register (0x43) shows the raw pending bits of every source, ignoring enables.
- R9: Writing 1s to the pending-set register (0x48) forces those sources pending. Writing them to 0x47 removes the forced request.
- R10: Source 0 takes no part in the priority logic. fiq_n is low while it is enabled and pending, and its handler address reads at 0x41.
- R11: With bit 0 of the control register (0x4B) set, a vector read returns the address with no side effect. A following write to 0x40 commits the push, status update and edge clear of that read.
- R12: The stack holds 8 entries. A push when it is full is dropped, and an end-of-interrupt write when it is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register word address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe; data is valid the next cycle |
| rd_data | output | 32 | Registered read data |
| src_in | input | 32 | Raw interrupt source inputs |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
The bench goes after a priority tie between sources 3 and 7. A selector that did not prefer the lower number would return the wrong handler there. It nests a level-6 source over a level-2 source and unwinds with two end-of-interrupt writes, which exposes a stack that masked only lower levels (and not equal ones) or popped the wrong entry. It fills the stack past its depth and then counts the pops needed before the request returns; a stack that wrapped on overflow or underflow would need a different number. Protect mode is checked by confirming that the status and request line are unchanged until the commit write.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    localparam int ADDR_W = 8;
    localparam int PRIO_W = 3;
    localparam int LVL_W  = PRIO_W + 1;
    localparam int IDX_W  = 5;
    localparam int CFG_W  = PRIO_W + 2;

    localparam logic [ADDR_W-1:0] A_CFG   = 8'h00;
    localparam logic [ADDR_W-1:0] A_VEC   = 8'h20;
    localparam logic [ADDR_W-1:0] A_IVR   = 8'h40;
    localparam logic [ADDR_W-1:0] A_FVR   = 8'h41;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h42;
    localparam logic [ADDR_W-1:0] A_PEND  = 8'h43;
    localparam logic [ADDR_W-1:0] A_MASK  = 8'h44;
    localparam logic [ADDR_W-1:0] A_ENSET = 8'h45;
    localparam logic [ADDR_W-1:0] A_ENCLR = 8'h46;
    localparam logic [ADDR_W-1:0] A_PCLR  = 8'h47;
    localparam logic [ADDR_W-1:0] A_PSET  = 8'h48;
    localparam logic [ADDR_W-1:0] A_EOI   = 8'h49;
    localparam logic [ADDR_W-1:0] A_SPUR  = 8'h4A;
    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h4B;

    typedef struct packed {
        logic              inv;
        logic              edge_trig;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    // stack levels are priority+1 so that 0 means "nothing masked"
    function automatic logic [LVL_W-1:0] lvl_of(input logic [PRIO_W-1:0] p);
        return {1'b0, p} + LVL_W'(1);
    endfunction
endpackage

// File: rtl/nirq_src_slot.sv
module nirq_src_slot (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic edge_trig,
    input  logic inv,
    input  logic force_set,
    input  logic force_clr,
    input  logic take,
    output logic pend
);
    logic eff, prev_q, latch_q, hit;

    assign eff = src ^ inv;
    assign hit = edge_trig & eff & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= eff;
            latch_q <= (latch_q & ~(force_clr | take)) | hit | force_set;
        end
    end

    assign pend = latch_q | (~edge_trig & eff);
endmodule

// File: rtl/nirq_select.sv
module nirq_select import nirq_pkg::*; #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [LVL_W-1:0]          thresh,
    output pick_t                     pick
);
    always_comb begin
        pick = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            logic [LVL_W-1:0] l;
            l = lvl_of(prio_flat[i*PRIO_W +: PRIO_W]);
            if (req[i] && (l > thresh) && (!pick.valid || l > pick.lvl)) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
                pick.lvl   = l;
            end
        end
    end
endmodule

// File: rtl/nirq_lvl_stack.sv
module nirq_lvl_stack import nirq_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LVL_W-1:0] push_val,
    input  logic             pop,
    output logic [LVL_W-1:0] thresh,
    output logic [CNT_W-1:0] cnt
);
    logic [LVL_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] top_p, wr_p;
    logic             empty, full, do_wr;
    logic [PTR_W-1:0] wr_at;

    assign empty  = (cnt == '0);
    assign full   = (cnt == CNT_W'(DEPTH));
    assign top_p  = PTR_W'(cnt - 1'b1);
    assign wr_p   = PTR_W'(cnt);
    assign thresh = empty ? '0 : mem[top_p];

    always_comb begin
        do_wr = 1'b0;
        wr_at = wr_p;
        if (push && pop && !empty) begin
            do_wr = 1'b1;
            wr_at = top_p;
        end else if (push && !pop && !full) begin
            do_wr = 1'b1;
        end else if (push && pop && empty) begin
            do_wr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && !pop && !full) begin
            cnt <= cnt + 1'b1;
        end else if (pop && !push && !empty) begin
            cnt <= cnt - 1'b1;
        end else if (push && pop && empty) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_at] <= push_val;
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl import nirq_pkg::*; #(
    parameter int NUM_SRC   = 32,
    parameter int VEC_W     = 32,
    parameter int STK_DEPTH = 8,
    localparam int CNT_W    = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [VEC_W-1:0]  wdata,
    input  logic              rd_en,
    output logic [VEC_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] src_in,
    output logic              irq_n,
    output logic              fiq_n
);
    src_cfg_t              cfg [NUM_SRC];
    logic [VEC_W-1:0]      vec [NUM_SRC];
    logic [NUM_SRC-1:0]    mask, pend, take, f_set, f_clr;
    logic [VEC_W-1:0]      spur_vec;
    logic                  protect;
    logic [IDX_W-1:0]      stat_q;
    pick_t                 pick, arm_q, cmt;
    logic                  armed_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [LVL_W-1:0]      thresh;
    logic [CNT_W-1:0]      stk_cnt;
    logic                  ivr_rd, ivr_wr, fvr_rd, now_cmt, late_cmt, commit, eoi;

    assign ivr_rd   = rd_en && addr == A_IVR;
    assign ivr_wr   = wr_en && addr == A_IVR;
    assign fvr_rd   = rd_en && addr == A_FVR;
    assign eoi      = wr_en && addr == A_EOI;
    assign now_cmt  = ivr_rd && !protect;
    assign late_cmt = ivr_wr && protect && armed_q;
    assign commit   = now_cmt || late_cmt;
    assign cmt      = now_cmt ? pick : arm_q;
    assign f_set    = (wr_en && addr == A_PSET) ? wdata[NUM_SRC-1:0] : '0;
    assign f_clr    = (wr_en && addr == A_PCLR) ? wdata[NUM_SRC-1:0] : '0;

    always_comb begin
        take = '0;
        if (commit && cmt.valid) take[cmt.idx] = 1'b1;
        if (fvr_rd) take[0] = 1'b1;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        nirq_src_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .src      (src_in[g]),
            .edge_trig(cfg[g].edge_trig),
            .inv      (cfg[g].inv),
            .force_set(f_set[g]),
            .force_clr(f_clr[g]),
            .take     (take[g]),
            .pend     (pend[g])
        );
        assign prio_flat[g*PRIO_W +: PRIO_W] = cfg[g].prio;
    end

    nirq_select #(.NUM_SRC(NUM_SRC)) u_sel (
        .req      (pend & mask),
        .prio_flat(prio_flat),
        .thresh   (thresh),
        .pick     (pick)
    );

    nirq_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk     (clk),
        .rst     (rst),
        .push    (commit),
        .push_val(cmt.valid ? cmt.lvl : thresh),
        .pop     (eoi),
        .thresh  (thresh),
        .cnt     (stk_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask     <= '0;
            spur_vec <= '0;
            protect  <= 1'b0;
            stat_q   <= '0;
            armed_q  <= 1'b0;
            arm_q    <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg[i] <= '0;
                vec[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_en && addr == A_CFG + ADDR_W'(i)) cfg[i] <= src_cfg_t'(wdata[CFG_W-1:0]);
                if (wr_en && addr == A_VEC + ADDR_W'(i)) vec[i] <= wdata;
            end
            if (wr_en && addr == A_ENSET) mask <= mask | wdata[NUM_SRC-1:0];
            if (wr_en && addr == A_ENCLR) mask <= mask & ~wdata[NUM_SRC-1:0];
            if (wr_en && addr == A_SPUR)  spur_vec <= wdata;
            if (wr_en && addr == A_CTRL)  protect  <= wdata[0];
            if (commit) stat_q <= cmt.valid ? cmt.idx : '0;
            if (ivr_rd && protect) begin
                armed_q <= 1'b1;
                arm_q   <= pick;
            end else if (late_cmt) begin
                armed_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (addr == A_CFG + ADDR_W'(i)) rd_data <= VEC_W'(cfg[i]);
                if (addr == A_VEC + ADDR_W'(i)) rd_data <= vec[i];
            end
            case (addr)
                A_IVR:  rd_data <= pick.valid ? vec[pick.idx] : spur_vec;
                A_FVR:  rd_data <= vec[0];
                A_STAT: rd_data <= VEC_W'(stat_q);
                A_PEND: rd_data <= VEC_W'(pend);
                A_MASK: rd_data <= VEC_W'(mask);
                A_SPUR: rd_data <= spur_vec;
                A_CTRL: rd_data <= VEC_W'(protect);
                default: ;
            endcase
        end
    end

    assign irq_n = ~pick.valid;
    assign fiq_n = ~(pend[0] & mask[0]);
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk import nirq_pkg::*; #(
    parameter int NUM_SRC   = 32,
    parameter int VEC_W     = 32,
    parameter int STK_DEPTH = 8,
    localparam int CNT_W    = $clog2(STK_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [VEC_W-1:0]  wdata,
    input logic              rd_en,
    input logic [VEC_W-1:0]  rd_data,
    input logic              irq_n,
    input logic              fiq_n,
    input logic [NUM_SRC-1:0] mask,
    input logic [CNT_W-1:0]  depth,
    input logic              protect,
    input logic [VEC_W-1:0]  spur_vec
);
    AST_EOI_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_EOI && depth == '0 && !(rd_en && addr == A_IVR)) |=> depth == '0); // R12
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(depth) <= STK_DEPTH); // R12
    AST_VECTOR_PUSH: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_IVR && !protect && !wr_en && int'(depth) < STK_DEPTH)
        |=> depth == $past(depth) + 1'b1); // R4
    AST_PROTECT_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_IVR && protect && !wr_en) |=> $stable(depth)); // R11
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_ENCLR) |=> (mask & $past(wdata[NUM_SRC-1:0])) == '0); // R2
    AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_IVR && irq_n) |=> rd_data == $past(spur_vec)); // R7
    AST_FIQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !fiq_n |-> mask[0]); // R10
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .STK_DEPTH(STK_DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n), .fiq_n(fiq_n),
    .mask(mask), .depth(stk_cnt), .protect(protect), .spur_vec(spur_vec)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rd_q = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [31:0] src = '0;
    logic        irq_n, fiq_n;
    int          n_chk = 0, n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    localparam logic [31:0] SPUR = 32'h0000_DEAD;

    always #10 clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rd_data(rd_data), .src_in(src), .irq_n(irq_n), .fiq_n(fiq_n)
    );

    function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    always @(posedge clk) rd_q <= rd_en;

    // monitor: pops expected read results from the scoreboard
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rd_data, e);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_src(input int i, input logic v);
        @(negedge clk); src[i] = v;
    endtask

    task automatic pin(input logic act_sel, input logic e, input string t);
        @(negedge clk);
        check(t, act_sel ? 32'(fiq_n) : 32'(irq_n), 32'(e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pin(0, 1'b1, "R1 irq_n idle");
        pin(1, 1'b1, "R1 fiq_n idle");
        rd(8'h44, 32'h0, "R1 enables clear");
        rd(8'h42, 32'h0, "R1 status clear");
        for (int i = 0; i < 16; i++) wr(8'h20 + 8'(i), 32'h100 + 32'(i));
        wr(8'h4A, SPUR);

        // level source 3, priority 2
        wr(8'h03, 32'h02);
        wr(8'h45, 32'h08);
        pin(0, 1'b1, "R5 low input no request");
        set_src(3, 1'b1);
        pin(0, 1'b0, "R5 high input requests");
        rd(8'h43, 32'h08, "R8 pending raw");
        rd(8'h40, 32'h103, "R3 vector of source 3");
        pin(0, 1'b1, "R4 equal level masked");
        rd(8'h42, 32'd3, "R8 status source 3");

        // edge source 5, priority 5, nests over level 2
        wr(8'h05, 32'h0D);
        wr(8'h45, 32'h20);
        rd(8'h44, 32'h28, "R2 set only written bits");
        set_src(5, 1'b1);
        set_src(5, 1'b0);
        pin(0, 1'b0, "R4 higher level nests");
        rd(8'h43, 32'h28, "R6 edge latched");
        rd(8'h40, 32'h105, "R3 vector of source 5");
        rd(8'h43, 32'h08, "R6 latch cleared on selection");
        pin(0, 1'b1, "R4 masked after nest");
        wr(8'h49, 32'h0);
        pin(0, 1'b1, "R4 still masked at level 2");
        wr(8'h49, 32'h0);
        pin(0, 1'b0, "R4 empty stack requests again");

        // tie between 3 and 7, then level 6 source 9
        wr(8'h07, 32'h02);
        set_src(7, 1'b1);
        wr(8'h45, 32'h80);
        rd(8'h40, 32'h103, "R3 tie lowest index");
        wr(8'h09, 32'h06);
        set_src(9, 1'b1);
        wr(8'h45, 32'h200);
        pin(0, 1'b0, "R4 level 6 above 2");
        rd(8'h40, 32'h109, "R3 highest priority wins");
        wr(8'h49, 32'h0);
        wr(8'h49, 32'h0);
        set_src(3, 1'b0); set_src(7, 1'b0); set_src(9, 1'b0);
        wr(8'h46, 32'h2A0);
        rd(8'h44, 32'h08, "R2 clear only written bits");
        wr(8'h46, 32'h08);
        rd(8'h44, 32'h0, "R2 all disabled");

        // spurious read, then inverted level source 4
        pin(0, 1'b1, "R7 nothing pending");
        rd(8'h40, SPUR, "R7 spurious vector");
        rd(8'h42, 32'h0, "R7 status zero on spurious");
        set_src(4, 1'b1);
        wr(8'h04, 32'h11);
        wr(8'h45, 32'h10);
        pin(0, 1'b1, "R5 inverted high idle");
        set_src(4, 1'b0);
        pin(0, 1'b0, "R5 inverted low requests");
        rd(8'h43, 32'h10, "R5 inverted pending bit");
        wr(8'h49, 32'h0);
        set_src(4, 1'b1);
        wr(8'h46, 32'h10);

        // forced assertion on edge source 10
        wr(8'h0A, 32'h0C);
        wr(8'h45, 32'h400);
        pin(0, 1'b1, "R9 idle before force");
        wr(8'h48, 32'h400);
        pin(0, 1'b0, "R9 forced request");
        rd(8'h43, 32'h400, "R9 forced pending");
        wr(8'h47, 32'h400);
        pin(0, 1'b1, "R6 clear register drops request");
        rd(8'h43, 32'h0, "R9 force cleared");
        wr(8'h46, 32'h400);

        // fast source 0
        wr(8'h00, 32'h07);
        set_src(0, 1'b1);
        wr(8'h45, 32'h1);
        pin(1, 1'b0, "R10 fast line low");
        pin(0, 1'b1, "R10 no normal request");
        rd(8'h41, 32'h100, "R10 fast vector");
        wr(8'h46, 32'h1);
        pin(1, 1'b1, "R10 fast disabled");
        set_src(0, 1'b0);

        // protect mode
        wr(8'h4B, 32'h1);
        wr(8'h0C, 32'h03);
        set_src(12, 1'b1);
        wr(8'h45, 32'h1000);
        rd(8'h40, 32'h10C, "R11 vector in protect mode");
        pin(0, 1'b0, "R11 no push on read");
        rd(8'h42, 32'h0, "R11 status unchanged");
        wr(8'h40, 32'h0);
        pin(0, 1'b1, "R11 push on commit write");
        rd(8'h42, 32'd12, "R11 status on commit");
        wr(8'h49, 32'h0);
        wr(8'h4B, 32'h0);
        set_src(12, 1'b0);
        wr(8'h46, 32'h1000);

        // stack depth and empty pops
        wr(8'h49, 32'h0);
        wr(8'h49, 32'h0);
        wr(8'h0D, 32'h00);
        set_src(13, 1'b1);
        wr(8'h45, 32'h2000);
        pin(0, 1'b0, "R12 level 0 requests after empty pops");
        rd(8'h40, 32'h10D, "R12 vector after empty pops");
        for (int k = 0; k < 8; k++) rd(8'h40, SPUR, "R12 spurious while full");
        for (int k = 0; k < 7; k++) wr(8'h49, 32'h0);
        pin(0, 1'b1, "R12 one entry left");
        wr(8'h49, 32'h0);
        pin(0, 1'b0, "R12 stack drained at depth 8");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule